// File: doc/BRIEF.md
# Sector Erase Accumulation Window

This block sits behind the command decoder of a NOR-style flash controller. A sector erase command marks one sector as pending and opens a time-out window. While the window is open, further sector erase commands add their sectors to the pending set, and each one restarts the full time-out. When the window runs out with no new command, the block raises a started flag, pulses a one-cycle erase-start strobe for the erase engine, and then refuses every command except suspend until the engine reports completion.

A chip erase issued while idle skips the window. It marks every sector pending and starts at once, without raising the started flag. A reset command issued while the window is open drops the pending set and starts nothing. The bus-cycle unlock decoding and the erase algorithm itself live outside this block.

Top module: `sector_erase_window`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle. After that edge, `pend_mask` is 0 and `erase_flag`, `erase_start` and `cmd_ignored` are 0. This also applies when reset arrives while a window is open.
- R2: In idle, a sector erase strobe sets bit `sector_idx` of `pend_mask` after the capturing edge. `erase_flag` stays 0 for as long as the window is open.
- R3: `erase_flag` rises exactly `TIMEOUT_CYCLES` clock edges after the edge that captured the last accepted sector erase. Every accepted sector erase reloads the full time-out, including a repeat of a sector that is already pending.
- R4: Each sector erase accepted in the window ORs its one-hot sector bit into `pend_mask`. Bits already set stay set.
- R5: `erase_start` is high for exactly one cycle, in the first cycle that `erase_flag` reads 1.
- R6: While `erase_flag` is 1, a sector erase, chip erase or reset command raises `cmd_ignored` one cycle later and changes neither `pend_mask` nor `erase_flag`. A suspend command is accepted and does not raise `cmd_ignored`.
- R7: In idle, a chip erase sets all bits of `pend_mask` and pulses `erase_start` after the capturing edge, with `erase_flag` held at 0. A chip erase issued inside a window raises `cmd_ignored` and leaves the window running.
- R8: `erase_done` during an erase clears `pend_mask` and `erase_flag` after the next edge and returns the block to idle.
- R9: A reset command inside the window clears `pend_mask` after the next edge. No `erase_start` and no `erase_flag` follow it.
- R10: A suspend command outside an erase raises `cmd_ignored` one cycle later and has no other effect.
- R11: A sector erase that arrives on the same edge at which the window would expire takes priority. It restarts the window, and the expiry does not happen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_sector_erase | input | 1 | Decoded sector erase command strobe |
| cmd_chip_erase | input | 1 | Decoded chip erase command strobe |
| cmd_suspend | input | 1 | Decoded erase suspend command strobe |
| cmd_reset | input | 1 | Decoded reset command strobe |
| sector_idx | input | IDX_W | Sector addressed by the sector erase strobe |
| erase_done | input | 1 | Erase engine reports completion |
| pend_mask | output | NUM_SECTORS | One bit per sector pending erase |
| erase_flag | output | 1 | Window expired, sector erase under way (reads 0 during the window) |
| erase_start | output | 1 | One-cycle pulse when the sector or chip erase starts |
| cmd_ignored | output | 1 | Pulse: the previous cycle's command was refused |

## Verification
Every output is registered, so the effect of a command strobe appears exactly one edge after the strobe is captured. The flag and the start pulse appear `TIMEOUT_CYCLES` edges after the last accepted sector erase. The bench drives each vector at a falling edge and compares all four outputs at the next falling edge, one rising edge later. It runs the bench with a short time-out so that each counted cycle of the window, including the restart on the expiry edge, has its own row in the vector table.

// File: rtl/sew_pkg.sv
// Shared types for the sector erase window.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sew_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WINDOW = 2'd1,
        ST_SECT   = 2'd2,
        ST_CHIP   = 2'd3
    } sew_state_t;
endpackage

// File: rtl/sew_timer.sv
// Restartable down-counter for the accumulation window.
// A load reloads the full time-out. While run is high the counter
// counts down to zero. Expire flags the cycle at zero with no reload.
// Assumes TIMEOUT >= 2.
module sew_timer #(
    parameter int TIMEOUT = 16,
    localparam int CW = $clog2(TIMEOUT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expire
);
    logic [CW-1:0] cnt;

    // Reload on each accepted command, otherwise count down in the window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= CW'(TIMEOUT - 1);
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Window ends when the count is exhausted and no reload arrives.
    always_comb expire = run && !load && (cnt == '0);

    AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == CW'(TIMEOUT - 1)); // R3
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt != '0) |=> cnt == $past(cnt) - 1'b1); // R3
endmodule

// File: rtl/sew_mask.sv
// Pending sector set, one bit per sector.
// Add ORs in the decoded sector, set_all marks every sector, clear empties.
// Assumes the controller never asserts add and clear together.
module sew_mask #(
    parameter int NUM = 8,
    localparam int IW = $clog2(NUM)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           add,
    input  logic [IW-1:0]  idx,
    input  logic           set_all,
    input  logic           clear,
    output logic [NUM-1:0] mask
);
    logic [NUM-1:0] hit;

    // One-hot decode of the addressed sector.
    for (genvar g = 0; g < NUM; g++) begin : g_dec
        assign hit[g] = (idx == IW'(g));
    end

    // Update the pending set from the controller's requests.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            mask <= '0;
        else if (set_all)
            mask <= '1;
        else if (add)
            mask <= mask | hit;
    end

    AST_ADD_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (add && !clear) |=> (mask & $past(hit)) == $past(hit)); // R4
    AST_ADD_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (add && !clear) |=> (mask & $past(mask)) == $past(mask)); // R4
endmodule

// File: rtl/sew_ctrl.sv
// Command sequencer for the erase window.
// Decides which command is accepted in each state and drives the timer
// and mask, plus the registered flag, start and ignored outputs.
// Assumes the command strobes are one-hot. Priority otherwise:
// reset, then suspend, then chip erase, then sector erase.
module sew_ctrl
    import sew_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_se,
    input  logic cmd_ce,
    input  logic cmd_sus,
    input  logic cmd_rst,
    input  logic erase_done,
    input  logic expire,
    output logic timer_load,
    output logic timer_run,
    output logic mask_add,
    output logic mask_set_all,
    output logic mask_clear,
    output logic erase_flag,
    output logic erase_start,
    output logic cmd_ignored
);
    sew_state_t state, state_n;
    logic start_n, ign_n;

    // Next-state and request decode per state.
    always_comb begin
        state_n      = state;
        timer_load   = 1'b0;
        mask_add     = 1'b0;
        mask_set_all = 1'b0;
        mask_clear   = 1'b0;
        start_n      = 1'b0;
        ign_n        = 1'b0;
        timer_run    = (state == ST_WINDOW);
        case (state)
            ST_IDLE: begin
                if (cmd_rst) begin
                    state_n = ST_IDLE;
                end else if (cmd_sus) begin
                    ign_n = 1'b1;
                end else if (cmd_ce) begin
                    mask_set_all = 1'b1;
                    start_n      = 1'b1;
                    state_n      = ST_CHIP;
                end else if (cmd_se) begin
                    mask_add   = 1'b1;
                    timer_load = 1'b1;
                    state_n    = ST_WINDOW;
                end
            end
            ST_WINDOW: begin
                if (cmd_rst) begin
                    mask_clear = 1'b1;
                    state_n    = ST_IDLE;
                end else if (cmd_se && !cmd_sus && !cmd_ce) begin
                    mask_add   = 1'b1;
                    timer_load = 1'b1;
                end else begin
                    ign_n = cmd_sus || cmd_ce;
                    if (expire) begin
                        start_n = 1'b1;
                        state_n = ST_SECT;
                    end
                end
            end
            default: begin
                ign_n = cmd_se || cmd_ce || cmd_rst;
                if (erase_done) begin
                    mask_clear = 1'b1;
                    state_n    = ST_IDLE;
                end
            end
        endcase
    end

    // State and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            erase_flag  <= 1'b0;
            erase_start <= 1'b0;
            cmd_ignored <= 1'b0;
        end else begin
            state       <= state_n;
            erase_flag  <= (state_n == ST_SECT);
            erase_start <= start_n;
            cmd_ignored <= ign_n;
        end
    end

    AST_FLAG_FROM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_flag) |-> $past(state) == ST_WINDOW); // R2
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start); // R5
    AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SECT && (cmd_se || cmd_ce || cmd_rst)) |=> cmd_ignored); // R6
    AST_SUSPEND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SECT && cmd_sus && !cmd_se && !cmd_ce && !cmd_rst) |=> !cmd_ignored); // R6
    AST_CHIP_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_CHIP |-> !erase_flag); // R7
    AST_RESET_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WINDOW && cmd_rst) |=> (!erase_start && !erase_flag)); // R9
    AST_IDLE_SUSPEND_IGN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cmd_sus && !cmd_rst) |=> cmd_ignored); // R10
endmodule

// File: rtl/sector_erase_window.sv
// Sector erase accumulation window: top level.
// Joins the sequencer, the restartable timer and the pending mask.
// Assumes decoded, single-cycle command strobes and a synchronous
// active-low reset. The erase engine reports completion on erase_done.
module sector_erase_window #(
    parameter int NUM_SECTORS    = 8,
    parameter int TIMEOUT_CYCLES = 16,
    localparam int IDX_W = $clog2(NUM_SECTORS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_sector_erase,
    input  logic                   cmd_chip_erase,
    input  logic                   cmd_suspend,
    input  logic                   cmd_reset,
    input  logic [IDX_W-1:0]       sector_idx,
    input  logic                   erase_done,
    output logic [NUM_SECTORS-1:0] pend_mask,
    output logic                   erase_flag,
    output logic                   erase_start,
    output logic                   cmd_ignored
);
    logic expire, timer_load, timer_run;
    logic mask_add, mask_set_all, mask_clear;

    sew_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_se       (cmd_sector_erase),
        .cmd_ce       (cmd_chip_erase),
        .cmd_sus      (cmd_suspend),
        .cmd_rst      (cmd_reset),
        .erase_done   (erase_done),
        .expire       (expire),
        .timer_load   (timer_load),
        .timer_run    (timer_run),
        .mask_add     (mask_add),
        .mask_set_all (mask_set_all),
        .mask_clear   (mask_clear),
        .erase_flag   (erase_flag),
        .erase_start  (erase_start),
        .cmd_ignored  (cmd_ignored)
    );

    sew_timer #(.TIMEOUT(TIMEOUT_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (timer_load),
        .run    (timer_run),
        .expire (expire)
    );

    sew_mask #(.NUM(NUM_SECTORS)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .add     (mask_add),
        .idx     (sector_idx),
        .set_all (mask_set_all),
        .clear   (mask_clear),
        .mask    (pend_mask)
    );

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_done && erase_flag) |=> (pend_mask == '0 && !erase_flag)); // R8
    AST_FLAG_HAS_SECTORS: assert property (@(posedge clk) disable iff (!rst_n)
        erase_flag |-> pend_mask != '0); // R4
endmodule

// File: tb/sector_erase_window_bench.sv
module sector_erase_window_bench;
    localparam int NS = 8;
    localparam int TO = 4;
    localparam int NV = 35;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, se, ce, sus, rcmd, done;
    logic [2:0] idx;
    logic [NS-1:0] pend_mask;
    logic erase_flag, erase_start, cmd_ignored;
    int nchk = 0;
    int nfail = 0;

    sector_erase_window #(.NUM_SECTORS(NS), .TIMEOUT_CYCLES(TO)) u_sector_erase_window (
        .clk(clk), .rst_n(rst_n),
        .cmd_sector_erase(se), .cmd_chip_erase(ce), .cmd_suspend(sus),
        .cmd_reset(rcmd), .sector_idx(idx), .erase_done(done),
        .pend_mask(pend_mask), .erase_flag(erase_flag),
        .erase_start(erase_start), .cmd_ignored(cmd_ignored)
    );

    // Row: {se,ce,sus,rst,done}, idx, expected mask, expected {flag,start,ignored}
    localparam logic [18:0] VEC [NV] = '{
        {5'b00000, 3'd0, 8'h00, 3'b000},  // 0  idle R1
        {5'b10000, 3'd2, 8'h04, 3'b000},  // 1  open window R2
        {5'b00000, 3'd0, 8'h04, 3'b000},  // 2  R2
        {5'b00000, 3'd0, 8'h04, 3'b000},  // 3  R2
        {5'b10000, 3'd5, 8'h24, 3'b000},  // 4  add sector R4
        {5'b00000, 3'd0, 8'h24, 3'b000},  // 5  R3
        {5'b00000, 3'd0, 8'h24, 3'b000},  // 6  R3
        {5'b00000, 3'd0, 8'h24, 3'b000},  // 7  R3
        {5'b00000, 3'd0, 8'h24, 3'b110},  // 8  expiry R3 R5
        {5'b00000, 3'd0, 8'h24, 3'b100},  // 9  pulse ends R5
        {5'b10000, 3'd0, 8'h24, 3'b101},  // 10 locked out R6
        {5'b00100, 3'd0, 8'h24, 3'b100},  // 11 suspend taken R6
        {5'b00010, 3'd0, 8'h24, 3'b101},  // 12 reset refused R6
        {5'b00001, 3'd0, 8'h00, 3'b000},  // 13 done R8
        {5'b01000, 3'd0, 8'hFF, 3'b010},  // 14 chip erase R7
        {5'b10000, 3'd1, 8'hFF, 3'b001},  // 15 refused during chip R7
        {5'b00001, 3'd0, 8'h00, 3'b000},  // 16 done R8
        {5'b00100, 3'd0, 8'h00, 3'b001},  // 17 idle suspend R10
        {5'b10000, 3'd3, 8'h08, 3'b000},  // 18 open window R2
        {5'b01000, 3'd0, 8'h08, 3'b001},  // 19 chip in window R7
        {5'b00010, 3'd0, 8'h00, 3'b000},  // 20 cancel R9
        {5'b00000, 3'd0, 8'h00, 3'b000},  // 21 R9
        {5'b00000, 3'd0, 8'h00, 3'b000},  // 22 R9
        {5'b00000, 3'd0, 8'h00, 3'b000},  // 23 R9
        {5'b00000, 3'd0, 8'h00, 3'b000},  // 24 R9
        {5'b10000, 3'd7, 8'h80, 3'b000},  // 25 open window R2
        {5'b00000, 3'd0, 8'h80, 3'b000},  // 26 R3
        {5'b00000, 3'd0, 8'h80, 3'b000},  // 27 R3
        {5'b00000, 3'd0, 8'h80, 3'b000},  // 28 R3
        {5'b10000, 3'd7, 8'h80, 3'b000},  // 29 repeat on expiry edge R11
        {5'b00000, 3'd0, 8'h80, 3'b000},  // 30 R11
        {5'b00000, 3'd0, 8'h80, 3'b000},  // 31 R11
        {5'b00000, 3'd0, 8'h80, 3'b000},  // 32 R11
        {5'b00000, 3'd0, 8'h80, 3'b110},  // 33 expiry R3
        {5'b00001, 3'd0, 8'h00, 3'b000}   // 34 done R8
    };
    localparam int REQ [NV] = '{1,2,2,2,4,3,3,3,3,5,6,6,6,8,7,7,8,10,2,7,
                                9,9,9,9,9,2,3,3,3,11,11,11,11,3,8};

    task automatic chk(input int req, input logic [7:0] em, input logic [2:0] ef);
        nchk++;
        if (pend_mask !== em || {erase_flag, erase_start, cmd_ignored} !== ef) begin
            nfail++;
            $display("FAIL R%0d: mask=%h fsi=%b expected mask=%h fsi=%b",
                     req, pend_mask, {erase_flag, erase_start, cmd_ignored}, em, ef);
        end
    endtask

    initial begin
        {se, ce, sus, rcmd, done} = '0;
        idx = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(1, 8'h00, 3'b000);  // R1 reset state
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            {se, ce, sus, rcmd, done} = VEC[i][18:14];
            idx = VEC[i][13:11];
            @(negedge clk);
            chk(REQ[i], VEC[i][10:3], VEC[i][2:0]);
        end
        {se, ce, sus, rcmd, done} = '0;
        // R1: line reset in the middle of a window
        se = 1'b1; idx = 3'd4;
        @(negedge clk);
        se = 1'b0;
        chk(2, 8'h10, 3'b000);
        rst_n = 1'b0;
        @(negedge clk);
        chk(1, 8'h00, 3'b000);
        rst_n = 1'b1;
        for (int k = 0; k < TO + 2; k++) begin
            @(negedge clk);
            chk(1, 8'h00, 3'b000);  // R1 window gone, nothing starts
        end
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        nfail++;
        $display("FAIL watchdog (R1): run still active, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule